// File: doc/BRIEF.md
# Reorder Buffer Retirement Controller

This block keeps a circular buffer of in-flight instructions in program order and retires them in order. Each cycle the rename stage may offer a small group of instructions, each tagged with a sequence number. Slots that rename has already cancelled are dropped, and the rest are appended at the tail. The execute stage reports finished instructions by sequence number through several completion ports. A completion marks the matching entry as ready, and it can also mark the entry as cancelled.

From the head, the controller retires up to a fixed number of entries per cycle. A cancelled entry at the head leaves without any commit report. A non-speculative instruction that reaches the head before it has run makes the controller ask execute to run it, and retirement stalls until that instruction completes.

A squash request from execute starts a walk from the tail that takes several cycles. Each walk cycle removes a bounded number of entries younger than the squash sequence number. During the walk, status is reported back to execute every cycle: the done sequence number, the squash flags, the number of free entries and the execute request for non-speculative instructions.

Top module: `rob_commit_ctrl`

## Requirements
- R1: After reset the buffer is empty, `fb_free_o` equals DEPTH, `ren_rdy_o` is high, and `cmt_vld_o`, `fb_sqing_o`, `fb_squash_o` and `fb_ns_vld_o` are all low.
- R2: When `ren_rdy_o` is high, the group size is the lesser of `ren_cnt_i` and RN_W. Slots 0 up to that size are appended in slot order. A slot whose `ren_kill_i` bit is set is skipped and uses no entry.
- R3: `ren_rdy_o` is low while a squash walk is in progress, and also whenever the free entries are fewer than the group size. While it is low, nothing is inserted.
- R4: Retirement goes in order from the head, at most CM_W entries per cycle, and stops at the first entry that is not ready. Committed sequence numbers appear on `cmt_seq_o` packed from slot 0, with `cmt_vld_o` as a low-aligned mask, one clock after the retiring cycle. A completion seen at one clock edge can be retired at the following edge.
- R5: When any instruction commits, `fb_done_vld_o` pulses and `fb_done_seq_o` carries the youngest sequence number committed in that cycle.
- R6: A ready head entry that execute marked as cancelled (`cp_kill_i`) is removed without a commit report. It still uses one of that cycle's CM_W retirement slots.
- R7: Entries inserted with `ren_ns_i` set are ready but not executed. When such an entry is at the head, `fb_ns_vld_o` pulses with its sequence number, retirement stops for that cycle, and the entry becomes not ready until a completion for it arrives. After that completion it commits normally.
- R8: The clock after a squash request is accepted, `fb_squash_o` and `fb_sqing_o` are high and `fb_done_seq_o` equals the squash sequence number. The mispredict, taken, next-PC and mispredicted-PC fields are forwarded unchanged.
- R9: In each walk cycle, up to SQ_PER entries whose sequence number is younger than the squash number are removed from the tail. Younger is judged by the modulo-2^8 difference being positive. In each walk cycle `fb_sqing_o` is high with `fb_squash_o` low, and `fb_done_seq_o` is the youngest remaining sequence number, or the squash number if the buffer is empty. Nothing is retired during the walk. The controller runs again after the cycle that removes the last younger entry.
- R10: Completions set the ready bit even in a walk cycle.
- R11: A group offered in the same cycle as an accepted squash request is inserted first, and the walk removes its younger members.
- R12: `fb_free_o` always equals DEPTH minus the number of occupied entries.
- R13: A squash request raised during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_cnt_i | input | GRP_W | Number of valid rename slots offered |
| ren_seq_i | input | RN_W x 8 | Sequence number for each rename slot |
| ren_ns_i | input | RN_W | Slot holds a non-speculative instruction |
| ren_kill_i | input | RN_W | Slot already cancelled; do not insert |
| ren_rdy_o | output | 1 | Group can be accepted this cycle |
| cp_vld_i | input | CP_W | Completion port valid |
| cp_seq_i | input | CP_W x 8 | Completed sequence number |
| cp_kill_i | input | CP_W | Completed instruction is cancelled |
| ex_sq_i | input | 1 | Squash request |
| ex_sq_seq_i | input | 8 | Squash sequence number (entries younger are removed) |
| ex_mispred_i | input | 1 | Mispredict flag to forward |
| ex_taken_i | input | 1 | Taken flag to forward |
| ex_npc_i | input | PC_W | Next PC to forward |
| ex_mpc_i | input | PC_W | Mispredicted PC to forward |
| cmt_vld_o | output | CM_W | Commit mask, low-aligned |
| cmt_seq_o | output | CM_W x 8 | Committed sequence numbers, oldest first |
| fb_done_vld_o | output | 1 | Done sequence number is meaningful |
| fb_done_seq_o | output | 8 | Done sequence number |
| fb_squash_o | output | 1 | Squash accepted |
| fb_sqing_o | output | 1 | Squash walk in progress |
| fb_mispred_o | output | 1 | Forwarded mispredict flag |
| fb_taken_o | output | 1 | Forwarded taken flag |
| fb_npc_o | output | PC_W | Forwarded next PC |
| fb_mpc_o | output | PC_W | Forwarded mispredicted PC |
| fb_free_o | output | CNT_W | Free entry count |
| fb_ns_vld_o | output | 1 | Request to execute a non-speculative instruction |
| fb_ns_seq_o | output | 8 | Sequence number of that instruction |

## Verification
The assertions assume that rename offers sequence numbers in increasing order. They also assume that the live sequence numbers never span more than half the 8-bit range, so the wrap-safe comparison stays meaningful, and that completions name only live entries. The stimulus issues sequence numbers in order, including one run that crosses 255 to 0, and it completes only instructions already inserted. Squash numbers are always taken from, or just older than, the live window, so the younger test selects exactly the intended tail entries.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int SEQ_W = 8;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        logic vld;
        seq_t seq;
        logic nonspec;
        logic killed;
        logic ready;
        logic executed;
    } rob_ent_t;

    typedef enum logic {ST_RUN, ST_WALK} ctl_st_e;

    // a is younger than b when the modulo difference is positive
    function automatic logic seq_younger(seq_t a, seq_t b);
        seq_t d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

endpackage

// File: rtl/rob_entry_store.sv
module rob_entry_store
    import rob_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int RN_W   = 2,
    parameter int CM_W   = 2,
    parameter int SQ_PER = 2,
    parameter int CP_W   = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1,
    localparam int GRP_W = $clog2(RN_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ins_en,
    input  logic [GRP_W-1:0]     ins_grp,
    input  seq_t [RN_W-1:0]      ins_seq,
    input  logic [RN_W-1:0]      ins_ns,
    input  logic [RN_W-1:0]      ins_kill,
    input  logic [IDX_W-1:0]     head,
    input  logic [IDX_W-1:0]     tail,
    input  logic [CNT_W-1:0]     ret_n,
    input  logic [CNT_W-1:0]     rm_n,
    input  logic                 ns_clr,
    input  logic [IDX_W-1:0]     ns_idx,
    input  logic [CP_W-1:0]      cp_vld,
    input  seq_t [CP_W-1:0]      cp_seq,
    input  logic [CP_W-1:0]      cp_kill,
    output logic [GRP_W-1:0]     ins_n,
    output rob_ent_t             ents [DEPTH]
);

    logic [RN_W-1:0]  wen;
    logic [IDX_W-1:0] wpos [RN_W];

    always_comb begin
        logic [GRP_W-1:0] off;
        off = '0;
        for (int k = 0; k < RN_W; k++) begin
            wen[k]  = ins_en && (GRP_W'(k) < ins_grp) && !ins_kill[k];
            wpos[k] = tail + IDX_W'(off);
            if (wen[k]) off = off + GRP_W'(1);
        end
        ins_n = off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
        end else begin
            for (int k = 0; k < CM_W; k++)
                if (CNT_W'(k) < ret_n) ents[head + IDX_W'(k)].vld <= 1'b0;
            for (int k = 0; k < SQ_PER; k++)
                if (CNT_W'(k) < rm_n) ents[tail - IDX_W'(k) - IDX_W'(1)].vld <= 1'b0;
            for (int k = 0; k < RN_W; k++)
                if (wen[k]) ents[wpos[k]] <= '{vld: 1'b1, seq: ins_seq[k], nonspec: ins_ns[k],
                                               killed: 1'b0, ready: ins_ns[k], executed: 1'b0};
            if (ns_clr) ents[ns_idx].ready <= 1'b0;
            for (int e = 0; e < DEPTH; e++)
                for (int p = 0; p < CP_W; p++)
                    if (cp_vld[p] && ents[e].vld && ents[e].seq == cp_seq[p]) begin
                        ents[e].ready    <= 1'b1;
                        ents[e].executed <= 1'b1;
                        if (cp_kill[p]) ents[e].killed <= 1'b1;
                    end
        end
    end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CM_W  = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  rob_ent_t          ents [DEPTH],
    input  logic [IDX_W-1:0]  head,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  ret_n,
    output logic [CM_W-1:0]   cmt_vld,
    output seq_t [CM_W-1:0]   cmt_seq,
    output seq_t              last_seq,
    output logic              ns_vld,
    output seq_t              ns_seq,
    output logic [IDX_W-1:0]  ns_idx
);

    always_comb begin
        logic stop;
        logic [CNT_W-1:0] ncmt;
        logic [IDX_W-1:0] idx;
        rob_ent_t e;
        stop     = 1'b0;
        ncmt     = '0;
        ret_n    = '0;
        cmt_vld  = '0;
        cmt_seq  = '0;
        last_seq = '0;
        ns_vld   = 1'b0;
        ns_seq   = '0;
        ns_idx   = '0;
        for (int k = 0; k < CM_W; k++) begin
            idx = head + IDX_W'(k);
            e   = ents[idx];
            if (!stop) begin
                if (CNT_W'(k) >= count || !e.vld || !e.ready) begin
                    stop = 1'b1;
                end else if (e.killed) begin
                    ret_n = ret_n + CNT_W'(1);
                end else if (e.nonspec && !e.executed) begin
                    ns_vld = 1'b1;
                    ns_seq = e.seq;
                    ns_idx = idx;
                    stop   = 1'b1;
                end else begin
                    cmt_vld[ncmt] = 1'b1;
                    cmt_seq[ncmt] = e.seq;
                    last_seq      = e.seq;
                    ncmt          = ncmt + CNT_W'(1);
                    ret_n         = ret_n + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rob_squash_walk.sv
module rob_squash_walk
    import rob_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int SQ_PER = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  seq_t              seqs [DEPTH],
    input  logic [IDX_W-1:0]  tail,
    input  logic [CNT_W-1:0]  count,
    input  seq_t              sq_seq,
    output logic [CNT_W-1:0]  rm_n,
    output logic              walk_done,
    output seq_t              tail_seq
);

    always_comb begin
        logic stop;
        logic more;
        logic yng;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] left;
        stop = 1'b0;
        more = 1'b0;
        rm_n = '0;
        for (int k = 0; k <= SQ_PER; k++) begin
            idx = tail - IDX_W'(k) - IDX_W'(1);
            yng = (CNT_W'(k) < count) && seq_younger(seqs[idx], sq_seq);
            if (k < SQ_PER) begin
                if (!stop && yng) rm_n = rm_n + CNT_W'(1);
                else              stop = 1'b1;
            end else begin
                more = !stop && yng;
            end
        end
        walk_done = !more;
        left      = count - rm_n;
        idx       = tail - IDX_W'(rm_n) - IDX_W'(1);
        tail_seq  = (left == '0) ? sq_seq : seqs[idx];
    end

endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int RN_W   = 2,
    parameter int CM_W   = 2,
    parameter int SQ_PER = 2,
    parameter int CP_W   = 2,
    parameter int PC_W   = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1,
    localparam int GRP_W = $clog2(RN_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GRP_W-1:0]     ren_cnt_i,
    input  seq_t [RN_W-1:0]      ren_seq_i,
    input  logic [RN_W-1:0]      ren_ns_i,
    input  logic [RN_W-1:0]      ren_kill_i,
    output logic                 ren_rdy_o,
    input  logic [CP_W-1:0]      cp_vld_i,
    input  seq_t [CP_W-1:0]      cp_seq_i,
    input  logic [CP_W-1:0]      cp_kill_i,
    input  logic                 ex_sq_i,
    input  seq_t                 ex_sq_seq_i,
    input  logic                 ex_mispred_i,
    input  logic                 ex_taken_i,
    input  logic [PC_W-1:0]      ex_npc_i,
    input  logic [PC_W-1:0]      ex_mpc_i,
    output logic [CM_W-1:0]      cmt_vld_o,
    output seq_t [CM_W-1:0]      cmt_seq_o,
    output logic                 fb_done_vld_o,
    output seq_t                 fb_done_seq_o,
    output logic                 fb_squash_o,
    output logic                 fb_sqing_o,
    output logic                 fb_mispred_o,
    output logic                 fb_taken_o,
    output logic [PC_W-1:0]      fb_npc_o,
    output logic [PC_W-1:0]      fb_mpc_o,
    output logic [CNT_W-1:0]     fb_free_o,
    output logic                 fb_ns_vld_o,
    output seq_t                 fb_ns_seq_o
);

    ctl_st_e          state;
    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    seq_t             sq_seq_q;

    rob_ent_t         ents [DEPTH];
    seq_t             seqs [DEPTH];
    logic [GRP_W-1:0] grp, ins_n;
    logic             running, walking, do_sq, do_ret;

    logic [CNT_W-1:0] ret_n, ret_eff, rm_n, rm_eff;
    logic [CM_W-1:0]  r_cmt_vld;
    seq_t [CM_W-1:0]  r_cmt_seq;
    seq_t             r_last_seq, r_ns_seq, w_tail_seq;
    logic             r_ns_vld, w_done;
    logic [IDX_W-1:0] r_ns_idx;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_seq
            assign seqs[i] = ents[i].seq;
        end
    endgenerate

    assign grp       = (ren_cnt_i > GRP_W'(RN_W)) ? GRP_W'(RN_W) : ren_cnt_i;
    assign fb_free_o = CNT_W'(DEPTH) - count;
    assign running   = (state == ST_RUN);
    assign walking   = (state == ST_WALK);
    assign ren_rdy_o = running && (fb_free_o >= CNT_W'(grp));
    assign do_sq     = running && ex_sq_i;
    assign do_ret    = running && !ex_sq_i;
    assign ret_eff   = do_ret ? ret_n : '0;
    assign rm_eff    = walking ? rm_n : '0;

    rob_entry_store #(
        .DEPTH(DEPTH), .RN_W(RN_W), .CM_W(CM_W), .SQ_PER(SQ_PER), .CP_W(CP_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ins_en  (ren_rdy_o),
        .ins_grp (grp),
        .ins_seq (ren_seq_i),
        .ins_ns  (ren_ns_i),
        .ins_kill(ren_kill_i),
        .head    (head),
        .tail    (tail),
        .ret_n   (ret_eff),
        .rm_n    (rm_eff),
        .ns_clr  (do_ret && r_ns_vld),
        .ns_idx  (r_ns_idx),
        .cp_vld  (cp_vld_i),
        .cp_seq  (cp_seq_i),
        .cp_kill (cp_kill_i),
        .ins_n   (ins_n),
        .ents    (ents)
    );

    rob_retire_sel #(.DEPTH(DEPTH), .CM_W(CM_W)) u_retire (
        .ents    (ents),
        .head    (head),
        .count   (count),
        .ret_n   (ret_n),
        .cmt_vld (r_cmt_vld),
        .cmt_seq (r_cmt_seq),
        .last_seq(r_last_seq),
        .ns_vld  (r_ns_vld),
        .ns_seq  (r_ns_seq),
        .ns_idx  (r_ns_idx)
    );

    rob_squash_walk #(.DEPTH(DEPTH), .SQ_PER(SQ_PER)) u_walk (
        .seqs     (seqs),
        .tail     (tail),
        .count    (count),
        .sq_seq   (sq_seq_q),
        .rm_n     (rm_n),
        .walk_done(w_done),
        .tail_seq (w_tail_seq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_RUN;
            head          <= '0;
            tail          <= '0;
            count         <= '0;
            sq_seq_q      <= '0;
            cmt_vld_o     <= '0;
            cmt_seq_o     <= '0;
            fb_done_vld_o <= 1'b0;
            fb_done_seq_o <= '0;
            fb_squash_o   <= 1'b0;
            fb_sqing_o    <= 1'b0;
            fb_mispred_o  <= 1'b0;
            fb_taken_o    <= 1'b0;
            fb_npc_o      <= '0;
            fb_mpc_o      <= '0;
            fb_ns_vld_o   <= 1'b0;
            fb_ns_seq_o   <= '0;
        end else begin
            head  <= head + IDX_W'(ret_eff);
            tail  <= tail + IDX_W'(ins_n) - IDX_W'(rm_eff);
            count <= count + CNT_W'(ins_n) - ret_eff - rm_eff;

            cmt_vld_o     <= do_ret ? r_cmt_vld : '0;
            cmt_seq_o     <= r_cmt_seq;
            fb_done_vld_o <= 1'b0;
            fb_squash_o   <= 1'b0;
            fb_sqing_o    <= 1'b0;
            fb_ns_vld_o   <= 1'b0;

            if (do_sq) begin
                state         <= ST_WALK;
                sq_seq_q      <= ex_sq_seq_i;
                fb_done_vld_o <= 1'b1;
                fb_done_seq_o <= ex_sq_seq_i;
                fb_squash_o   <= 1'b1;
                fb_sqing_o    <= 1'b1;
                fb_mispred_o  <= ex_mispred_i;
                fb_taken_o    <= ex_taken_i;
                fb_npc_o      <= ex_npc_i;
                fb_mpc_o      <= ex_mpc_i;
            end else if (walking) begin
                fb_done_vld_o <= 1'b1;
                fb_done_seq_o <= w_tail_seq;
                fb_sqing_o    <= 1'b1;
                if (w_done) state <= ST_RUN;
            end else begin
                if (r_cmt_vld != '0) begin
                    fb_done_vld_o <= 1'b1;
                    fb_done_seq_o <= r_last_seq;
                end
                fb_ns_vld_o <= r_ns_vld;
                fb_ns_seq_o <= r_ns_seq;
            end
        end
    end

endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
    parameter int DEPTH = 16,
    parameter int CM_W  = 2,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             ren_rdy_o,
    input logic [CM_W-1:0]  cmt_vld_o,
    input logic             fb_done_vld_o,
    input logic             fb_squash_o,
    input logic             fb_sqing_o,
    input logic [CNT_W-1:0] fb_free_o,
    input logic             fb_ns_vld_o
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fb_free_o <= CNT_W'(DEPTH)); // R12
    AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ren_rdy_o |=> fb_free_o >= $past(fb_free_o)); // R3
    AST_CMT_PACKED: assert property (@(posedge clk) disable iff (rst)
        ((cmt_vld_o + CM_W'(1)) & cmt_vld_o) == '0); // R4
    AST_DONE_ON_CMT: assert property (@(posedge clk) disable iff (rst)
        (cmt_vld_o != '0) |-> fb_done_vld_o); // R5
    AST_WALK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        fb_squash_o |=> (fb_sqing_o && !fb_squash_o)); // R13
    AST_WALK_NO_RETIRE: assert property (@(posedge clk) disable iff (rst)
        fb_sqing_o |-> (cmt_vld_o == '0)); // R9
    AST_NS_NOT_WALK: assert property (@(posedge clk) disable iff (rst)
        fb_ns_vld_o |-> !fb_sqing_o); // R7

endmodule

bind rob_commit_ctrl rob_commit_chk #(.DEPTH(DEPTH), .CM_W(CM_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ren_rdy_o    (ren_rdy_o),
    .cmt_vld_o    (cmt_vld_o),
    .fb_done_vld_o(fb_done_vld_o),
    .fb_squash_o  (fb_squash_o),
    .fb_sqing_o   (fb_sqing_o),
    .fb_free_o    (fb_free_o),
    .fb_ns_vld_o  (fb_ns_vld_o)
);

// File: tb/rob_commit_ctrl_test.sv
module rob_commit_ctrl_test;
    import rob_pkg::*;

    localparam int DEPTH = 16;
    localparam int RN_W  = 2;
    localparam int CM_W  = 2;
    localparam int CP_W  = 2;
    localparam int PC_W  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]        ren_cnt_i = '0;
    seq_t [RN_W-1:0]   ren_seq_i = '0;
    logic [RN_W-1:0]   ren_ns_i = '0, ren_kill_i = '0;
    logic              ren_rdy_o;
    logic [CP_W-1:0]   cp_vld_i = '0, cp_kill_i = '0;
    seq_t [CP_W-1:0]   cp_seq_i = '0;
    logic              ex_sq_i = 1'b0, ex_mispred_i = 1'b0, ex_taken_i = 1'b0;
    seq_t              ex_sq_seq_i = '0;
    logic [PC_W-1:0]   ex_npc_i = '0, ex_mpc_i = '0;
    logic [CM_W-1:0]   cmt_vld_o;
    seq_t [CM_W-1:0]   cmt_seq_o;
    logic              fb_done_vld_o, fb_squash_o, fb_sqing_o, fb_mispred_o, fb_taken_o;
    seq_t              fb_done_seq_o, fb_ns_seq_o;
    logic [PC_W-1:0]   fb_npc_o, fb_mpc_o;
    logic [4:0]        fb_free_o;
    logic              fb_ns_vld_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rob_commit_ctrl uut (.*);

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ren_cnt_i = 0; ren_kill_i = '0; ren_ns_i = '0;
        cp_vld_i = '0; cp_kill_i = '0; ex_sq_i = 1'b0;
    endtask

    task automatic ren(int cnt, int s0, int s1, bit k0 = 0, bit k1 = 0, bit n0 = 0, bit n1 = 0);
        ren_cnt_i = 2'(cnt);
        ren_seq_i[0] = seq_t'(s0); ren_seq_i[1] = seq_t'(s1);
        ren_kill_i = {k1, k0}; ren_ns_i = {n1, n0};
    endtask

    task automatic cmp(bit v0, int s0, bit v1, int s1, bit k0 = 0);
        cp_vld_i = {v1, v0};
        cp_seq_i[0] = seq_t'(s0); cp_seq_i[1] = seq_t'(s1);
        cp_kill_i = {1'b0, k0};
    endtask

    task automatic t_reset();
        chk("R1 free", fb_free_o, 16);
        chk("R1 rdy", ren_rdy_o, 1);
        chk("R1 cmt", cmt_vld_o, 0);
        chk("R1 flags", {fb_sqing_o, fb_squash_o, fb_ns_vld_o}, 0);
    endtask

    task automatic t_in_order();
        ren(2, 1, 2); tick();
        ren(1, 3, 99); tick();
        idle();
        chk("R2 free after 3 inserts", fb_free_o, 13);
        cmp(1, 2, 0, 0); tick(); idle(); tick();
        chk("R4 head not ready blocks", cmt_vld_o, 0);
        cmp(1, 1, 1, 3); tick(); idle(); tick();
        chk("R4 width limited mask", cmt_vld_o, 3);
        chk("R4 order slot0", cmt_seq_o[0], 1);
        chk("R4 order slot1", cmt_seq_o[1], 2);
        chk("R5 done seq", fb_done_seq_o, 2);
        tick();
        chk("R4 remaining", cmt_vld_o, 1);
        chk("R4 remaining seq", cmt_seq_o[0], 3);
        chk("R12 free empty", fb_free_o, 16);
    endtask

    task automatic t_clamp();
        ren(3, 60, 61); tick(); idle();
        chk("R2 clamp to width", fb_free_o, 14);
        cmp(1, 60, 1, 61); tick(); idle(); tick();
        chk("R2 clamp commits", cmt_vld_o, 3);
        chk("R2 clamp seq", cmt_seq_o[1], 61);
    endtask

    task automatic t_kill();
        ren(2, 10, 11, 1, 0); tick();
        chk("R2 killed slot skipped", fb_free_o, 15);
        ren(2, 12, 13); tick(); idle();
        cmp(1, 11, 1, 12, 1); tick();
        cmp(1, 13, 0, 0); tick(); idle();
        chk("R6 silent retire mask", cmt_vld_o, 1);
        chk("R6 next commits", cmt_seq_o[0], 12);
        chk("R6 done not killed", fb_done_seq_o, 12);
        tick();
        chk("R6 slot consumed", cmt_seq_o[0], 13);
        chk("R6 free", fb_free_o, 16);
    endtask

    task automatic t_nonspec();
        ren(2, 20, 21, 0, 0, 1, 0); tick(); idle();
        cmp(0, 0, 1, 21); tick(); idle();
        chk("R7 request", fb_ns_vld_o, 1);
        chk("R7 request seq", fb_ns_seq_o, 20);
        chk("R7 stall", cmt_vld_o, 0);
        tick();
        chk("R7 request once", fb_ns_vld_o, 0);
        chk("R7 still stalled", cmt_vld_o, 0);
        cmp(1, 20, 0, 0); tick(); idle(); tick();
        chk("R7 commits after exec", cmt_vld_o, 3);
        chk("R7 commit seq", cmt_seq_o[0], 20);
    endtask

    task automatic t_full_squash();
        for (int i = 0; i < 8; i++) begin
            ren(2, 100 + 2 * i, 101 + 2 * i); tick();
        end
        chk("R12 full", fb_free_o, 0);
        ren(1, 200, 0);
        #1 chk("R3 refuse when full", ren_rdy_o, 0);
        tick();
        chk("R3 nothing inserted", fb_free_o, 0);
        idle();
        ex_sq_i = 1; ex_sq_seq_i = 99; ex_mispred_i = 1; ex_taken_i = 0;
        ex_npc_i = 16'h1234; ex_mpc_i = 16'h0abc;
        tick();
        chk("R8 squash", fb_squash_o, 1);
        chk("R8 sqing", fb_sqing_o, 1);
        chk("R8 done seq", fb_done_seq_o, 99);
        chk("R8 fwd", {fb_mispred_o, fb_taken_o}, 2);
        chk("R8 npc", fb_npc_o, 16'h1234);
        chk("R8 mpc", fb_mpc_o, 16'h0abc);
        ex_sq_seq_i = 110; ren(2, 200, 201);
        #1 chk("R3 refuse during walk", ren_rdy_o, 0);
        tick(); idle();
        chk("R9 tail seq", fb_done_seq_o, 113);
        chk("R9 two removed", fb_free_o, 2);
        chk("R13 no new squash", fb_squash_o, 0);
        for (int i = 0; i < 7; i++) tick();
        chk("R9 last walk", fb_sqing_o, 1);
        chk("R9 empty done", fb_done_seq_o, 99);
        chk("R9 emptied", fb_free_o, 16);
        tick();
        chk("R9 back running", fb_sqing_o, 0);
        chk("R13 ignored", fb_squash_o, 0);
    endtask

    task automatic t_same_cycle();
        ren(2, 50, 51); tick();
        ren(2, 52, 53); ex_sq_i = 1; ex_sq_seq_i = 51; tick(); idle();
        chk("R11 inserted first", fb_free_o, 12);
        cmp(1, 50, 0, 0); tick(); idle();
        chk("R11 younger removed", fb_free_o, 14);
        chk("R9 remaining tail", fb_done_seq_o, 51);
        tick();
        chk("R10 completion in walk", cmt_vld_o, 1);
        chk("R10 seq", cmt_seq_o[0], 50);
        cmp(1, 51, 0, 0); tick(); idle(); tick();
        chk("R4 after walk", cmt_seq_o[0], 51);
    endtask

    task automatic t_wrap();
        ren(2, 254, 255); tick();
        ren(2, 0, 1); tick(); idle();
        ex_sq_i = 1; ex_sq_seq_i = 255; tick(); idle();
        tick();
        chk("R9 wrap tail", fb_done_seq_o, 255);
        chk("R9 wrap removed", fb_free_o, 14);
        tick();
        chk("R9 wrap finished", fb_sqing_o, 0);
        cmp(1, 254, 1, 255); tick(); idle(); tick();
        chk("R9 wrap survivors", cmt_vld_o, 3);
        chk("R12 final free", fb_free_o, 16);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_in_order();
        t_clamp();
        t_kill();
        t_nonspec();
        t_full_squash();
        t_same_cycle();
        t_wrap();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule